// File: doc/BRIEF.md
# Floating-Point Error Reporting Controller

This block decides when a processor core tells external interrupt hardware about an unmasked floating-point exception while the core runs in its legacy compatibility reporting mode. Each exception event arrives with a class code and the kind of instruction that raised it. The block records the first such exception and classifies it as either immediate or deferred. An immediate exception drives the active-low error pin at once. A deferred exception waits silently until the issue stage decodes the next waiting instruction, meaning a floating-point instruction or a WAIT. In both cases the issue stage is stalled through the freeze output in front of that next waiting instruction. No-wait control instructions always pass.

The error pin is meant to feed interrupt request line 13 of a cascaded interrupt controller. The interrupt acknowledge input releases the freeze so that the handler can run. The handler then drops the pending exception with a one-cycle clear strobe. An active-low ignore input lets the handler execute diagnostic floating-point instructions without being frozen. When the ignore input is released with the error still pending, normal reporting resumes. A mode input set to 1 selects native reporting, and in that mode this logic stays completely quiet.

Top module: `fperr_report`

## Requirements
- R1: After reset, errN is 1 and freeze is 0, and no exception is pending, so a following floating-point instruction (nextKind 1) is not frozen.
- R2: While modeNative is 1, errN is 1 and freeze is 0, and an exception presented then is not recorded.
- R3: An exception is immediate when its origin is store (excOrg 2) and its class is not precision (excCls 5), or when its origin is special, meaning transcendental, scale, extract or partial remainder (excOrg 1), and its class is invalid (0), denormal (1) or stack fault (6). With ignoreN high, errN goes to 0 in the cycle after the clock edge that records it, even when no waiting instruction is decoded.
- R4: Every other exception is deferred. This covers basic arithmetic (excOrg 0) of any class, precision (excCls 5) from any origin, and overflow (3) or underflow (4) from any non-store origin. errN stays 1 until a floating-point (nextKind 1) or WAIT (nextKind 2) instruction is decoded. In that same cycle freeze goes to 1 and errN goes to 0.
- R5: A no-wait control instruction (nextKind 3) never causes freeze, even with an error pending.
- R6: An immediate exception that is still pending also raises freeze when a floating-point or WAIT instruction is decoded.
- R7: While ignoreN is 0, freeze stays 0, and a pending exception whose pin has not yet been driven does not drive errN to 0.
- R8: When ignoreN returns to 1 with the exception still pending, reporting resumes. An immediate exception drives errN to 0 at once, and a deferred one drives errN to 0 and raises freeze at the next waiting instruction.
- R9: Freeze holds while a waiting instruction stays decoded, until intAck is sampled. After that, freeze is 0 for that exception, and errN stays 0.
- R10: A sampled clearPend drops the pending exception. In the next cycle errN is 1 and freeze is 0. An exception presented in the same cycle as clearPend is discarded.
- R11: Once errN has gone to 0, it stays 0 until clearPend is sampled, even if ignoreN becomes 0 (while modeNative is 0).
- R12: A further exception presented while one is already pending does not change the recorded reporting class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| excValid | input | 1 | An unmasked exception event is presented this cycle |
| excCls | input | 3 | Exception class: 0 invalid, 1 denormal, 2 divide by zero, 3 overflow, 4 underflow, 5 precision, 6 stack fault |
| excOrg | input | 2 | Raising instruction: 0 basic arithmetic, 1 special (transcendental/scale/extract/remainder), 2 store, 3 other |
| nextKind | input | 2 | Next decoded instruction: 0 none, 1 floating-point, 2 WAIT, 3 no-wait control |
| modeNative | input | 1 | 1 selects native reporting; compatibility reporting runs only at 0 |
| ignoreN | input | 1 | Ignore-error request, active low |
| clearPend | input | 1 | Handler strobe that clears the pending exception |
| intAck | input | 1 | External interrupt delivered; releases the freeze |
| errN | output | 1 | Error pin, active low |
| freeze | output | 1 | Stall request to the issue stage |

## Verification
The bench aims at the boundary between the immediate and deferred classes. It uses store precision, special-origin overflow and special-origin invalid, because a wrong classifier would drive the pin early or leave it silent until the next waiting instruction. It toggles the ignore input across a pending error to catch three faults: a design that freezes while ignoring, one that fails to re-arm on release, and one that drops an already driven pin. It also puts the clear strobe and a new exception in the same cycle, sends a second exception while one is pending, and uses the acknowledge input. A design with the wrong priority, one that overwrites the recorded class, or one that keeps stalling after the interrupt would freeze or drive the pin in cycles where the requirements forbid it.

// File: rtl/fperr_pkg.sv
package fperr_pkg;
  localparam int CLS_W  = 3;
  localparam int ORG_W  = 2;
  localparam int KIND_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INVALID = 3'd0,
    CLS_DENORM  = 3'd1,
    CLS_ZDIV    = 3'd2,
    CLS_OVFL    = 3'd3,
    CLS_UNFL    = 3'd4,
    CLS_PREC    = 3'd5,
    CLS_STACK   = 3'd6,
    CLS_RSVD    = 3'd7
  } excCls_e;

  typedef enum logic [ORG_W-1:0] {
    ORG_ARITH   = 2'd0,
    ORG_SPECIAL = 2'd1,
    ORG_STORE   = 2'd2,
    ORG_OTHER   = 2'd3
  } excOrg_e;

  typedef enum logic [KIND_W-1:0] {
    NXT_NONE   = 2'd0,
    NXT_FP     = 2'd1,
    NXT_WAIT   = 2'd2,
    NXT_NOWAIT = 2'd3
  } nxtKind_e;

  // strobes from control to the state registers
  typedef struct packed {
    logic record;
    logic recImm;
    logic clear;
    logic latchPin;
    logic ackRelease;
  } ctrlStrb_t;
endpackage

// File: rtl/fperr_classify.sv
module fperr_classify
  import fperr_pkg::*;
(
  input  logic [CLS_W-1:0] excCls,
  input  logic [ORG_W-1:0] excOrg,
  output logic             isImm
);
  logic storeHit;
  logic specialHit;

  always_comb begin
    storeHit   = (excOrg == ORG_STORE) && (excCls != CLS_PREC);
    specialHit = (excOrg == ORG_SPECIAL) &&
                 ((excCls == CLS_INVALID) || (excCls == CLS_DENORM) ||
                  (excCls == CLS_STACK));
    isImm      = storeHit || specialHit;
  end
endmodule

// File: rtl/fperr_ctrl.sv
module fperr_ctrl
  import fperr_pkg::*;
(
  input  logic              excValid,
  input  logic              excImm,
  input  logic [KIND_W-1:0] nextKind,
  input  logic              modeNative,
  input  logic              ignoreN,
  input  logic              clearPend,
  input  logic              intAck,
  input  logic              pendQ,
  input  logic              immQ,
  input  logic              latchQ,
  input  logic              ackQ,
  output ctrlStrb_t         strb,
  output logic              pinOn,
  output logic              freezeOn
);
  logic active;
  logic waitingInstr;

  always_comb begin
    active       = pendQ && !modeNative;
    waitingInstr = (nextKind == NXT_FP) || (nextKind == NXT_WAIT);
    freezeOn     = active && ignoreN && waitingInstr && !ackQ;
    pinOn        = active && (latchQ || (ignoreN && (immQ || waitingInstr)));

    strb.clear      = clearPend;
    strb.record     = excValid && !modeNative && !pendQ;
    strb.recImm     = excImm;
    strb.latchPin   = pinOn && !latchQ;
    strb.ackRelease = intAck && freezeOn;
  end
endmodule

// File: rtl/fperr_state.sv
module fperr_state
  import fperr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  output logic      pendQ,
  output logic      immQ,
  output logic      latchQ,
  output logic      ackQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= 1'b0;
      immQ   <= 1'b0;
      latchQ <= 1'b0;
      ackQ   <= 1'b0;
    end else if (strb.clear) begin
      pendQ  <= 1'b0;
      immQ   <= 1'b0;
      latchQ <= 1'b0;
      ackQ   <= 1'b0;
    end else begin
      if (strb.record) begin
        pendQ  <= 1'b1;
        immQ   <= strb.recImm;
        latchQ <= 1'b0;
        ackQ   <= 1'b0;
      end
      if (strb.latchPin)   latchQ <= 1'b1;
      if (strb.ackRelease) ackQ   <= 1'b1;
    end
  end
endmodule

// File: rtl/fperr_report.sv
module fperr_report
  import fperr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [CLS_W-1:0]  excCls,
  input  logic [ORG_W-1:0]  excOrg,
  input  logic [KIND_W-1:0] nextKind,
  input  logic              modeNative,
  input  logic              ignoreN,
  input  logic              clearPend,
  input  logic              intAck,
  output logic              errN,
  output logic              freeze
);
  logic      excImm;
  logic      pendQ, immQ, latchQ, ackQ;
  logic      pinOn, freezeOn;
  ctrlStrb_t strb;

  fperr_classify u_cls (
    .excCls (excCls),
    .excOrg (excOrg),
    .isImm  (excImm)
  );

  fperr_ctrl u_ctrl (
    .excValid   (excValid),
    .excImm     (excImm),
    .nextKind   (nextKind),
    .modeNative (modeNative),
    .ignoreN    (ignoreN),
    .clearPend  (clearPend),
    .intAck     (intAck),
    .pendQ      (pendQ),
    .immQ       (immQ),
    .latchQ     (latchQ),
    .ackQ       (ackQ),
    .strb       (strb),
    .pinOn      (pinOn),
    .freezeOn   (freezeOn)
  );

  fperr_state u_state (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pendQ  (pendQ),
    .immQ   (immQ),
    .latchQ (latchQ),
    .ackQ   (ackQ)
  );

  assign errN   = !pinOn;
  assign freeze = freezeOn;
endmodule

// File: rtl/fperr_report_chk.sv
module fperr_report_chk
  import fperr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [KIND_W-1:0] nextKind,
  input logic              modeNative,
  input logic              ignoreN,
  input logic              clearPend,
  input logic              intAck,
  input logic              errN,
  input logic              freeze
);
  // R2
  native_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeNative |-> (errN && !freeze));

  // R5
  nowait_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nextKind == NXT_NOWAIT) |-> !freeze);

  // R7
  ignore_nofreeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ignoreN |-> !freeze);

  // R10
  clear_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearPend |=> (errN && !freeze));

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && freeze) |=> !freeze);

  // R11
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!errN && !clearPend) |=> (!errN || modeNative));

  // R4
  freeze_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeze |-> !errN);
endmodule

bind fperr_report fperr_report_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .nextKind   (nextKind),
  .modeNative (modeNative),
  .ignoreN    (ignoreN),
  .clearPend  (clearPend),
  .intAck     (intAck),
  .errN       (errN),
  .freeze     (freeze)
);

// File: tb/sim_fperr_report.sv
`timescale 1ns/1ps
module sim_fperr_report;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       excValid = 1'b0;
  logic [2:0] excCls = 3'd0;
  logic [1:0] excOrg = 2'd0;
  logic [1:0] nextKind = 2'd0;
  logic       modeNative = 1'b0;
  logic       ignoreN = 1'b1;
  logic       clearPend = 1'b0;
  logic       intAck = 1'b0;
  logic       errN;
  logic       freeze;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic mPend = 1'b0, mImm = 1'b0, mLatch = 1'b0, mAck = 1'b0;

  always #2 clk = ~clk;

  fperr_report u0 (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCls(excCls),
    .excOrg(excOrg), .nextKind(nextKind), .modeNative(modeNative),
    .ignoreN(ignoreN), .clearPend(clearPend), .intAck(intAck),
    .errN(errN), .freeze(freeze)
  );

  function automatic logic refImm(input logic [2:0] c, input logic [1:0] o);
    case (o)
      2'd2:    return c != 3'd5;
      2'd1:    return (c == 3'd0) || (c == 3'd1) || (c == 3'd6);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic refWaiting();
    return (nextKind == 2'd1) || (nextKind == 2'd2);
  endfunction

  function automatic logic refFreeze();
    return mPend && !modeNative && ignoreN && refWaiting() && !mAck;
  endfunction

  function automatic logic refPin();
    return mPend && !modeNative && (mLatch || (ignoreN && (mImm || refWaiting())));
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] c, input logic [1:0] o,
                       input logic [1:0] k, input logic ign, input logic clr,
                       input logic ack, input logic nat);
    excValid = v; excCls = c; excOrg = o; nextKind = k;
    ignoreN = ign; clearPend = clr; intAck = ack; modeNative = nat;
    #1;
  endtask

  task automatic idle(input logic [1:0] k);
    drive(1'b0, 3'd0, 2'd0, k, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  // advance one clock, updating the reference with the sampled inputs
  task automatic tick();
    logic pinNow, frzNow;
    @(posedge clk);
    pinNow = refPin();
    frzNow = refFreeze();
    if (clearPend) begin
      mPend = 1'b0; mImm = 1'b0; mLatch = 1'b0; mAck = 1'b0;
    end else begin
      if (excValid && !modeNative && !mPend) begin
        mPend = 1'b1; mImm = refImm(excCls, excOrg); mLatch = 1'b0; mAck = 1'b0;
      end else begin
        if (pinNow) mLatch = 1'b1;
        if (intAck && frzNow) mAck = 1'b1;
      end
    end
    @(negedge clk);
  endtask

  task automatic expect2(input string tag, input logic eErr, input logic eFrz);
    chk(tag, "errN", errN, eErr);
    chk(tag, "freeze", freeze, eFrz);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seedV;
    seedV = 32'h5eed_0013;
    void'($urandom(seedV));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    idle(2'd0); expect2("R1", 1'b1, 1'b0);
    idle(2'd1); expect2("R1", 1'b1, 1'b0);
    tick();

    // R3, R6, R9, R10: store overflow is immediate
    drive(1'b1, 3'd3, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    idle(2'd0); expect2("R3", 1'b0, 1'b0); tick();
    idle(2'd1); expect2("R6", 1'b0, 1'b1); tick();
    idle(2'd1); expect2("R9", 1'b0, 1'b1);
    drive(1'b0, 3'd0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0); tick();
    idle(2'd1); expect2("R9", 1'b0, 1'b0);
    drive(1'b0, 3'd0, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0); tick();
    idle(2'd1); expect2("R10", 1'b1, 1'b0); tick();

    // R4, R5: arithmetic divide by zero is deferred
    drive(1'b1, 3'd2, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    idle(2'd0); expect2("R4", 1'b1, 1'b0); tick();
    idle(2'd3); expect2("R5", 1'b1, 1'b0); tick();
    idle(2'd2); expect2("R4", 1'b0, 1'b1); tick();
    idle(2'd3); expect2("R5", 1'b0, 1'b0); tick();
    drive(1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); tick();

    // R4: store precision and special overflow are deferred
    drive(1'b1, 3'd5, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    idle(2'd0); expect2("R4", 1'b1, 1'b0);
    drive(1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); tick();
    drive(1'b1, 3'd3, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    idle(2'd0); expect2("R4", 1'b1, 1'b0);
    drive(1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); tick();

    // R3: special invalid is immediate
    drive(1'b1, 3'd0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    idle(2'd0); expect2("R3", 1'b0, 1'b0);
    drive(1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); tick();

    // R7, R8: ignore with an immediate store invalid
    drive(1'b1, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); tick();
    drive(1'b0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); expect2("R7", 1'b1, 1'b0); tick();
    drive(1'b0, 3'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0); expect2("R7", 1'b1, 1'b0); tick();
    idle(2'd1); expect2("R8", 1'b0, 1'b1);
    drive(1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); tick();

    // R7, R8, R11: ignore with a deferred arithmetic exception
    drive(1'b1, 3'd3, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    drive(1'b0, 3'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0); expect2("R7", 1'b1, 1'b0); tick();
    idle(2'd2); expect2("R8", 1'b0, 1'b1); tick();
    drive(1'b0, 3'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0); expect2("R11", 1'b0, 1'b0); tick();
    drive(1'b0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); expect2("R11", 1'b0, 1'b0);
    drive(1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); tick();
    idle(2'd0); expect2("R10", 1'b1, 1'b0); tick();

    // R10: clear beats an exception in the same cycle
    drive(1'b1, 3'd0, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); tick();
    idle(2'd1); expect2("R10", 1'b1, 1'b0); tick();

    // R2: native mode is quiet and records nothing
    drive(1'b1, 3'd0, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1); expect2("R2", 1'b1, 1'b0); tick();
    idle(2'd1); expect2("R2", 1'b1, 1'b0); tick();

    // R12: a second exception does not change the class
    drive(1'b1, 3'd2, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    drive(1'b1, 3'd0, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); tick();
    idle(2'd0); expect2("R12", 1'b1, 1'b0);
    drive(1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); tick();

    // random phase against the reference
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 8) == 0, 3'($urandom % 7), 2'($urandom % 4),
            2'($urandom % 4), ($urandom % 8) != 0, ($urandom % 24) == 0,
            ($urandom % 8) == 0, ($urandom % 40) == 0);
      chk("R4", "errN", errN, !refPin());
      chk("R9", "freeze", freeze, refFreeze());
      tick();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule